// File: doc/BRIEF.md
# Frame DMA register init sequencer

This block brings up a video frame-buffer DMA engine without a processor. On a start pulse it programs the engine's stream-to-memory (write) channel, its memory-to-stream (read) channel, or both. For each channel it issues a series of single-beat AXI4-Lite writes in a fixed order. The last write of a channel sets the vertical size, and that write is what sets the channel moving video, so nothing follows it for that channel.

A channel's programming starts with its control register, with the run bit forced on. Then come the frame-buffer start addresses 1 to N, the combined frame-delay/stride word, the horizontal size and the vertical size. When both channels are selected, the write channel is programmed in full before the read channel. Each write waits for its response. A response other than OKAY stops the run and reports the offset that failed.

Configuration inputs other than the start pulse, the channel mask and the frame-buffer count are read live while the run is in progress. They must be held stable until done or error.

Top module: `fbdma_init_seq`

## Requirements
- R1: After reset awvalid_o, wvalid_o, bready_o, busy_o, done_o and err_o are all 0.
- R2: For each selected channel the writes go in this order: control, frame-buffer address 1 through N in ascending order, frame-delay/stride, horizontal size, vertical size. The vertical-size write is the last write of that channel.
- R3: chan_mask_i bit 0 selects the write channel, whose offsets are control 0x30, address k at 0xAC+4·(k−1), frame-delay/stride 0xA8, horizontal 0xA4 and vertical 0xA0. Bit 1 selects the read channel, whose offsets are 0x00, 0x5C+4·(k−1), 0x58, 0x54 and 0x50.
- R4: With both mask bits set, all N+4 write-channel writes come before the N+4 read-channel writes, so a run makes 2·(N+4) writes in total.
- R5: The control write carries ctrl_bits_i with bit 0 (run) forced to 1. Address k carries bits [32·(k−1)+31 : 32·(k−1)] of that channel's address vector (fb_addr_wr_i or fb_addr_rd_i). The horizontal and vertical writes carry hsize_i and vsize_i, zero-extended.
- R6: The frame-delay/stride word holds stride_i in bits 15:0 and the frame delay in bits 28:24. All other bits are 0. The delay is frm_dly_i when that channel's genlock_slave_i bit is set (bit 0 for the write channel, bit 1 for the read channel) and 0 otherwise.
- R7: N is nfb_i sampled at start. A value of 0 is used as 1, and a value above 16 is used as 16.
- R8: Each write raises awvalid_o and wvalid_o in the same cycle, with wstrb_o all ones. Each valid holds, with its address or data stable, until its ready. bready_o is raised only after both have been accepted, and no new write begins before the response handshake.
- R9: done_o is high for exactly one cycle. That cycle follows the response handshake of the final write when the response is OKAY. A start with chan_mask_i = 0 makes no writes and pulses done_o in the cycle after start.
- R10: A response other than OKAY (bresp_i ≠ 2'b00) sets err_o from the next cycle and sets err_addr_o to that write's offset. No further write is issued, busy_o falls, done_o does not pulse, and err_o stays set until the next accepted start.
- R11: A start pulse while busy_o is high is ignored, and the run in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| chan_mask_i | input | 2 | Bit 0 selects the write channel, bit 1 the read channel |
| nfb_i | input | 5 | Number of frame buffers |
| ctrl_bits_i | input | 32 | Control word, including interrupt enables |
| genlock_slave_i | input | 2 | Per-channel genlock-slave flag |
| frm_dly_i | input | 5 | Frame delay |
| stride_i | input | 16 | Line stride in bytes |
| hsize_i | input | 16 | Horizontal size in bytes |
| vsize_i | input | 16 | Vertical size in lines |
| fb_addr_wr_i | input | 512 | Write-channel buffer addresses, 32 bits each |
| fb_addr_rd_i | input | 512 | Read-channel buffer addresses, 32 bits each |
| awaddr_o | output | 8 | Register offset |
| awvalid_o | output | 1 | Write address valid |
| awready_i | input | 1 | Write address ready |
| wdata_o | output | 32 | Write data |
| wstrb_o | output | 4 | Write strobes, all ones |
| wvalid_o | output | 1 | Write data valid |
| wready_i | input | 1 | Write data ready |
| bresp_i | input | 2 | Write response |
| bvalid_i | input | 1 | Response valid |
| bready_o | output | 1 | Response ready |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky abort flag |
| err_addr_o | output | 8 | Offset of the failed write |

## Verification
A write counts as issued on the clock edge where its address handshake completes, and its data is taken on the edge where its data handshake completes. Both are recorded against an edge counter, so random ready and response delays do not shift any expected value. done_o must be seen on the edge right after the final response handshake (edge+1), and on the edge right after the start edge when the mask is empty. The rise of err_o must be seen on the edge after the failing response. Static state such as reset values and the sticky error flag is sampled on falling edges, away from any update.

// File: rtl/fis_pkg.sv
package fis_pkg;
  localparam int DLY_W  = 5;
  localparam int SIZE_W = 16;
  localparam int DLY_LSB = 24;

  localparam int CH_WR = 0;
  localparam int CH_RD = 1;

  // control offsets sit apart; the rest is a window per channel
  localparam logic [7:0] CTRL_OFS_WR = 8'h30;
  localparam logic [7:0] CTRL_OFS_RD = 8'h00;
  localparam logic [7:0] WIN_OFS_WR  = 8'hA0;
  localparam logic [7:0] WIN_OFS_RD  = 8'h50;
  localparam logic [7:0] REL_VS  = 8'h00;
  localparam logic [7:0] REL_HS  = 8'h04;
  localparam logic [7:0] REL_FDS = 8'h08;
  localparam logic [7:0] REL_FB  = 8'h0C;

  typedef enum logic [2:0] {
    STP_CTRL = 3'd0,
    STP_FB   = 3'd1,
    STP_FDS  = 3'd2,
    STP_HS   = 3'd3,
    STP_VS   = 3'd4
  } step_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2
  } state_e;
endpackage

// File: rtl/fis_step_gen.sv
module fis_step_gen
  import fis_pkg::*;
#(
  parameter int NFB_MAX = 16,
  parameter int AW      = 8,
  parameter int DW      = 32,
  parameter int IDXW    = 4
) (
  input  logic                  chan_i,
  input  step_e                 step_i,
  input  logic [IDXW-1:0]       idx_i,
  input  logic [DW-1:0]         ctrl_bits_i,
  input  logic [1:0]            genlock_slave_i,
  input  logic [DLY_W-1:0]      frm_dly_i,
  input  logic [SIZE_W-1:0]     stride_i,
  input  logic [SIZE_W-1:0]     hsize_i,
  input  logic [SIZE_W-1:0]     vsize_i,
  input  logic [NFB_MAX*DW-1:0] fb_addr_wr_i,
  input  logic [NFB_MAX*DW-1:0] fb_addr_rd_i,
  output logic [AW-1:0]         addr_o,
  output logic [DW-1:0]         data_o
);
  logic [AW-1:0]    ctrl_ofs [2];
  logic [AW-1:0]    win_ofs  [2];
  logic [DLY_W-1:0] dly_g    [2];
  logic [DW-1:0]    fb_sel   [2];
  logic [DW-1:0]    fds_word;
  logic [AW-1:0]    fb_step;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    localparam logic [7:0] CO = (c == CH_RD) ? CTRL_OFS_RD : CTRL_OFS_WR;
    localparam logic [7:0] WO = (c == CH_RD) ? WIN_OFS_RD  : WIN_OFS_WR;
    assign ctrl_ofs[c] = AW'(CO);
    assign win_ofs[c]  = AW'(WO);
    assign dly_g[c]    = genlock_slave_i[c] ? frm_dly_i : '0;
  end

  assign fb_sel[CH_WR] = fb_addr_wr_i[idx_i*DW +: DW];
  assign fb_sel[CH_RD] = fb_addr_rd_i[idx_i*DW +: DW];
  assign fb_step       = AW'({idx_i, 2'b00});

  always_comb begin
    fds_word = '0;
    fds_word[SIZE_W-1:0] = stride_i;
    fds_word[DLY_LSB +: DLY_W] = dly_g[chan_i];
  end

  always_comb begin
    addr_o = '0;
    data_o = '0;
    unique case (step_i)
      STP_CTRL: begin
        addr_o = ctrl_ofs[chan_i];
        data_o = ctrl_bits_i | DW'(1);
      end
      STP_FB: begin
        addr_o = win_ofs[chan_i] + AW'(REL_FB) + fb_step;
        data_o = fb_sel[chan_i];
      end
      STP_FDS: begin
        addr_o = win_ofs[chan_i] + AW'(REL_FDS);
        data_o = fds_word;
      end
      STP_HS: begin
        addr_o = win_ofs[chan_i] + AW'(REL_HS);
        data_o = DW'(hsize_i);
      end
      STP_VS: begin
        addr_o = win_ofs[chan_i] + AW'(REL_VS);
        data_o = DW'(vsize_i);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fis_axil_wr.sv
module fis_axil_wr #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic [AW-1:0] awaddr_o,
  output logic          awvalid_o,
  input  logic          awready_i,
  output logic [DW-1:0] wdata_o,
  output logic          wvalid_o,
  input  logic          wready_i,
  input  logic [1:0]    bresp_i,
  input  logic          bvalid_i,
  output logic          bready_o,
  output logic          fin_o,
  output logic [1:0]    resp_o
);
  logic act_q, aw_q, w_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      aw_q   <= 1'b0;
      w_q    <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (req_i && !act_q) begin
      act_q  <= 1'b1;
      aw_q   <= 1'b1;
      w_q    <= 1'b1;
      addr_q <= addr_i;
      data_q <= data_i;
    end else begin
      if (aw_q && awready_i) aw_q <= 1'b0;
      if (w_q && wready_i)   w_q  <= 1'b0;
      if (bready_o && bvalid_i) act_q <= 1'b0;
    end
  end

  assign awaddr_o  = addr_q;
  assign awvalid_o = aw_q;
  assign wdata_o   = data_q;
  assign wvalid_o  = w_q;
  assign bready_o  = act_q && !aw_q && !w_q;
  assign fin_o     = bready_o && bvalid_i;
  assign resp_o    = bresp_i;

  AST_AW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    awvalid_o && !awready_i |=> awvalid_o && $stable(awaddr_o)); // R8
  AST_W_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wvalid_o && !wready_i |=> wvalid_o && $stable(wdata_o)); // R8
  AST_REQ_WHEN_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> !act_q); // R8
  AST_BREADY_AFTER_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bready_o |-> !awvalid_o && !wvalid_o); // R8
endmodule

// File: rtl/fis_ctrl.sv
module fis_ctrl
  import fis_pkg::*;
#(
  parameter int NFB_MAX = 16,
  parameter int AW      = 8,
  parameter int NFB_W   = 5,
  parameter int IDXW    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       mask_i,
  input  logic [NFB_W-1:0] nfb_i,
  input  logic             fin_i,
  input  logic [1:0]       resp_i,
  input  logic [AW-1:0]    addr_i,
  output logic             chan_o,
  output step_e            step_o,
  output logic [IDXW-1:0]  idx_o,
  output logic             req_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [AW-1:0]    err_addr_o
);
  state_e          state_q;
  logic [1:0]      mask_q;
  logic [IDXW-1:0] last_idx_q;

  function automatic logic [IDXW-1:0] clamp_last(input logic [NFB_W-1:0] n);
    if (n == '0)                        return '0;
    else if (n > NFB_W'(NFB_MAX))       return IDXW'(NFB_MAX - 1);
    else                                return IDXW'(n - 1'b1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      mask_q     <= '0;
      last_idx_q <= '0;
      chan_o     <= 1'b0;
      step_o     <= STP_CTRL;
      idx_o      <= '0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
      err_addr_o <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          err_o <= 1'b0;
          if (mask_i == 2'b00) begin
            done_o <= 1'b1;
          end else begin
            mask_q     <= mask_i;
            last_idx_q <= clamp_last(nfb_i);
            chan_o     <= mask_i[CH_WR] ? 1'(CH_WR) : 1'(CH_RD);
            step_o     <= STP_CTRL;
            idx_o      <= '0;
            state_q    <= S_ISSUE;
          end
        end
        S_ISSUE: state_q <= S_WAIT;
        S_WAIT: if (fin_i) begin
          if (resp_i != 2'b00) begin
            err_o      <= 1'b1;
            err_addr_o <= addr_i;
            state_q    <= S_IDLE;
          end else begin
            state_q <= S_ISSUE;
            unique case (step_o)
              STP_CTRL: begin
                step_o <= STP_FB;
                idx_o  <= '0;
              end
              STP_FB: begin
                if (idx_o == last_idx_q) step_o <= STP_FDS;
                else                     idx_o  <= idx_o + 1'b1;
              end
              STP_FDS: step_o <= STP_HS;
              STP_HS:  step_o <= STP_VS;
              default: begin
                if (chan_o == 1'(CH_WR) && mask_q[CH_RD]) begin
                  chan_o <= 1'(CH_RD);
                  step_o <= STP_CTRL;
                end else begin
                  done_o  <= 1'b1;
                  state_q <= S_IDLE;
                end
              end
            endcase
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_o  = (state_q == S_ISSUE);
  assign busy_o = (state_q != S_IDLE);

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_NOT_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !err_o); // R10
  AST_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && step_o == STP_FB |-> idx_o <= last_idx_q); // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o && !start_i |=> err_o); // R10
endmodule

// File: rtl/fbdma_init_seq.sv
module fbdma_init_seq
  import fis_pkg::*;
#(
  parameter int NFB_MAX = 16,
  parameter int AW      = 8,
  parameter int DW      = 32,
  localparam int NFB_W  = $clog2(NFB_MAX + 1),
  localparam int IDXW   = (NFB_MAX > 1) ? $clog2(NFB_MAX) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [1:0]            chan_mask_i,
  input  logic [NFB_W-1:0]      nfb_i,
  input  logic [DW-1:0]         ctrl_bits_i,
  input  logic [1:0]            genlock_slave_i,
  input  logic [DLY_W-1:0]      frm_dly_i,
  input  logic [SIZE_W-1:0]     stride_i,
  input  logic [SIZE_W-1:0]     hsize_i,
  input  logic [SIZE_W-1:0]     vsize_i,
  input  logic [NFB_MAX*DW-1:0] fb_addr_wr_i,
  input  logic [NFB_MAX*DW-1:0] fb_addr_rd_i,
  output logic [AW-1:0]         awaddr_o,
  output logic                  awvalid_o,
  input  logic                  awready_i,
  output logic [DW-1:0]         wdata_o,
  output logic [DW/8-1:0]       wstrb_o,
  output logic                  wvalid_o,
  input  logic                  wready_i,
  input  logic [1:0]            bresp_i,
  input  logic                  bvalid_i,
  output logic                  bready_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  err_o,
  output logic [AW-1:0]         err_addr_o
);
  logic            chan;
  step_e           step;
  logic [IDXW-1:0] idx;
  logic            req, fin;
  logic [1:0]      resp;
  logic [AW-1:0]   cur_addr;
  logic [DW-1:0]   cur_data;

  fis_ctrl #(.NFB_MAX(NFB_MAX), .AW(AW), .NFB_W(NFB_W), .IDXW(IDXW)) ctrl_i (
    .clk_i, .rst_ni, .start_i,
    .mask_i(chan_mask_i), .nfb_i,
    .fin_i(fin), .resp_i(resp), .addr_i(cur_addr),
    .chan_o(chan), .step_o(step), .idx_o(idx), .req_o(req),
    .busy_o, .done_o, .err_o, .err_addr_o
  );

  fis_step_gen #(.NFB_MAX(NFB_MAX), .AW(AW), .DW(DW), .IDXW(IDXW)) step_i (
    .chan_i(chan), .step_i(step), .idx_i(idx),
    .ctrl_bits_i, .genlock_slave_i, .frm_dly_i, .stride_i,
    .hsize_i, .vsize_i, .fb_addr_wr_i, .fb_addr_rd_i,
    .addr_o(cur_addr), .data_o(cur_data)
  );

  fis_axil_wr #(.AW(AW), .DW(DW)) wr_i (
    .clk_i, .rst_ni, .req_i(req), .addr_i(cur_addr), .data_i(cur_data),
    .awaddr_o, .awvalid_o, .awready_i, .wdata_o, .wvalid_o, .wready_i,
    .bresp_i, .bvalid_i, .bready_o, .fin_o(fin), .resp_o(resp)
  );

  assign wstrb_o = '1;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !awvalid_o && !wvalid_o && !bready_o); // R10
  AST_VALIDS_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(awvalid_o) |-> $rose(wvalid_o)); // R8
endmodule

// File: tb/fbdma_init_seq_tb_top.sv
`timescale 1ns/1ps
module fbdma_init_seq_tb_top;
  localparam int NM = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #2.5 clk_i = ~clk_i;

  logic          start_i = 0;
  logic [1:0]    chan_mask_i = 0;
  logic [4:0]    nfb_i = 0;
  logic [31:0]   ctrl_bits_i = 0;
  logic [1:0]    genlock_slave_i = 0;
  logic [4:0]    frm_dly_i = 0;
  logic [15:0]   stride_i = 0, hsize_i = 0, vsize_i = 0;
  logic [NM*32-1:0] fb_addr_wr_i = '0, fb_addr_rd_i = '0;
  logic [7:0]    awaddr_o;
  logic          awvalid_o, wvalid_o, bready_o;
  logic          awready_i = 0, wready_i = 0, bvalid_i = 0;
  logic [31:0]   wdata_o;
  logic [3:0]    wstrb_o;
  logic [1:0]    bresp_i = 0;
  logic          busy_o, done_o, err_o;
  logic [7:0]    err_addr_o;

  fbdma_init_seq dut_i (.*);

  int tests = 0, fails = 0;
  int cyc = 0;
  logic [7:0]  rec_a [64];
  logic [31:0] rec_d [64];
  logic [7:0]  exp_a [64];
  logic [31:0] exp_d [64];
  int n_rec = 0, n_exp = 0;
  int err_at = -1;
  int prot_err = 0, done_cnt = 0, done_cyc = 0, last_b_cyc = 0, err_cyc = 0;
  logic got_aw = 0, got_w = 0, prev_aw = 0, prev_w = 0, prev_err = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // slave model and monitor; reads pre-edge values, drives with NBA
  initial begin
    forever begin
      @(posedge clk_i);
      cyc++;
      if (rst_ni) begin
        if (awvalid_o && !prev_aw && !(wvalid_o && !prev_w)) prot_err++;
        if (awvalid_o && !prev_aw && (got_aw || got_w)) prot_err++;
        if (bready_o && !(got_aw && got_w)) prot_err++;
        if (wvalid_o && wstrb_o != 4'hF) prot_err++;
        if (done_o) begin done_cnt++; done_cyc = cyc; end
        if (err_o && !prev_err) err_cyc = cyc;
        prev_aw = awvalid_o; prev_w = wvalid_o; prev_err = err_o;
        if (bvalid_i && bready_o) begin
          n_rec++; last_b_cyc = cyc;
          got_aw = 0; got_w = 0;
          bvalid_i <= 1'b0;
        end else begin
          if (awvalid_o && awready_i) begin got_aw = 1; if (n_rec < 64) rec_a[n_rec] = awaddr_o; end
          if (wvalid_o && wready_i) begin got_w = 1; if (n_rec < 64) rec_d[n_rec] = wdata_o; end
          if (got_aw && got_w && !bvalid_i && $urandom_range(0, 2) != 0) begin
            bvalid_i <= 1'b1;
            bresp_i  <= (n_rec == err_at) ? 2'b10 : 2'b00;
          end
        end
        awready_i <= !got_aw && ($urandom_range(0, 2) != 0);
        wready_i  <= !got_w && ($urandom_range(0, 2) != 0);
      end
    end
  end

  task automatic push(input logic [7:0] a, input logic [31:0] d);
    exp_a[n_exp] = a; exp_d[n_exp] = d; n_exp++;
  endtask

  task automatic add_chan(input int ch, input int n);
    logic [4:0] dly;
    dly = genlock_slave_i[ch] ? frm_dly_i : 5'd0;
    push(ch ? 8'h00 : 8'h30, ctrl_bits_i | 32'd1);
    for (int k = 0; k < n; k++)
      push((ch ? 8'h5C : 8'hAC) + 8'(4 * k), ch ? fb_addr_rd_i[k*32 +: 32] : fb_addr_wr_i[k*32 +: 32]);
    push(ch ? 8'h58 : 8'hA8, {3'b0, dly, 8'b0, stride_i});
    push(ch ? 8'h54 : 8'hA4, {16'b0, hsize_i});
    push(ch ? 8'h50 : 8'hA0, {16'b0, vsize_i});
  endtask

  task automatic randomize_cfg();
    ctrl_bits_i = $urandom;
    genlock_slave_i = 2'($urandom);
    frm_dly_i = 5'($urandom);
    stride_i = 16'($urandom); hsize_i = 16'($urandom); vsize_i = 16'($urandom);
    for (int k = 0; k < NM; k++) begin
      fb_addr_wr_i[k*32 +: 32] = $urandom;
      fb_addr_rd_i[k*32 +: 32] = $urandom;
    end
  endtask

  task automatic run(input logic [1:0] mask, input logic [4:0] nfb, input int fail_at,
                     input bit poke, input string tag);
    int n, d0, start_cyc;
    n = (nfb == 0) ? 1 : (nfb > 16 ? 16 : int'(nfb));
    n_exp = 0;
    if (mask[0]) add_chan(0, n);
    if (mask[1]) add_chan(1, n);
    n_rec = 0; err_at = fail_at; prot_err = 0;
    d0 = done_cnt;
    chan_mask_i = mask; nfb_i = nfb;
    @(negedge clk_i); start_i = 1;
    @(negedge clk_i); start_i = 0; start_cyc = cyc;
    check(err_o == 0, {tag, " R10 err cleared by start"}, err_o, 0);
    if (poke) begin
      repeat (4) @(negedge clk_i);
      chan_mask_i = ~mask; nfb_i = 5'd2; start_i = 1;
      @(negedge clk_i); start_i = 0;
    end
    while (done_cnt == d0 && !err_o) @(negedge clk_i);
    repeat (4) @(negedge clk_i);
    check(prot_err == 0, {tag, " R8 handshake rules"}, prot_err, 0);
    if (mask == 2'b00) begin
      check(n_rec == 0, {tag, " R9 no writes on empty mask"}, n_rec, 0);
      check(done_cyc == start_cyc + 1, {tag, " R9 empty-mask done timing"}, done_cyc, start_cyc + 1);
    end else if (fail_at >= 0) begin
      check(n_rec == fail_at + 1, {tag, " R10 writes stop after error"}, n_rec, fail_at + 1);
      check(err_o && err_addr_o == exp_a[fail_at], {tag, " R10 err_addr"}, err_addr_o, exp_a[fail_at]);
      check(err_cyc == last_b_cyc + 1, {tag, " R10 err timing"}, err_cyc, last_b_cyc + 1);
      check(done_cnt == d0 && !busy_o, {tag, " R10 no done, idle"}, done_cnt - d0, 0);
    end else begin
      check(n_rec == n_exp, {tag, " R4 R7 write count"}, n_rec, n_exp);
      for (int i = 0; i < n_exp && i < n_rec; i++) begin
        check(rec_a[i] == exp_a[i], {tag, " R2 R3 offset order"}, rec_a[i], exp_a[i]);
        check(rec_d[i] == exp_d[i], {tag, " R5 R6 data"}, rec_d[i], exp_d[i]);
      end
      check(done_cnt == d0 + 1, {tag, " R9 single done"}, done_cnt - d0, 1);
      check(done_cyc == last_b_cyc + 1, {tag, " R9 done timing"}, done_cyc, last_b_cyc + 1);
      if (poke) check(n_rec == n_exp, {tag, " R11 start while busy ignored"}, n_rec, n_exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    check(!awvalid_o && !wvalid_o && !bready_o && !busy_o && !done_o && !err_o,
          "R1 outputs during reset", {awvalid_o, wvalid_o, bready_o, busy_o, done_o, err_o}, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    check(!awvalid_o && !busy_o && !done_o && !err_o, "R1 idle after reset",
          {awvalid_o, busy_o, done_o, err_o}, 0);
    randomize_cfg();
    run(2'b01, 5'd1, -1, 0, "wr only n1");
    randomize_cfg();
    run(2'b10, 5'd16, -1, 0, "rd only n16");
    randomize_cfg(); genlock_slave_i = 2'b01;
    run(2'b11, 5'd3, -1, 0, "both n3 slave wr");
    randomize_cfg(); genlock_slave_i = 2'b10;
    run(2'b11, 5'd2, -1, 0, "both n2 slave rd");
    randomize_cfg();
    run(2'b11, 5'd0, -1, 0, "R7 clamp zero");
    randomize_cfg();
    run(2'b01, 5'd20, -1, 0, "R7 clamp high");
    run(2'b00, 5'd4, -1, 0, "empty mask");
    randomize_cfg();
    run(2'b11, 5'd4, 0, 0, "err first");
    randomize_cfg();
    run(2'b11, 5'd4, 9, 0, "err mid");
    randomize_cfg();
    run(2'b10, 5'd5, 8, 0, "err on vsize");
    randomize_cfg();
    run(2'b11, 5'd6, -1, 1, "R11 poke");
    for (int r = 0; r < 20; r++) begin
      randomize_cfg();
      run(2'($urandom_range(1, 3)), 5'($urandom_range(0, 20)),
          ($urandom_range(0, 3) == 0) ? $urandom_range(0, 4) : -1,
          $urandom_range(0, 1) == 1, "random");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule